// File: doc/BRIEF.md
# Configurable Parallel CRC Engine

This block is a register-mapped CRC accelerator. A bus master first writes a control word that picks one of four fixed generator polynomials (one 32-bit, three 16-bit), the input granularity (whole 32-bit word or a single byte), the input reordering, the output reversal and the initial register value. The master, or a DMA-style write strobe, then pushes data words. Each data word is folded into the running CRC in one clock. With back-to-back writes the engine absorbs 32 data bits per clock.

The CRC register shifts most significant bit first and is not reflected. In the 16-bit polynomial modes only the low half of the register is live. A result read returns the register through an optional bit-reversal stage. That stage acts only on the value being read and never on the running state. Read data is registered and appears one clock after the read request.

Top module: `crc_accel`

## Requirements
- R1: After a synchronous active-high reset the CRC state is zero and the control field is zero. A read of the result address (2) returns 0 and a read of the control address (0) returns 0. Reads of address 3 return 0.
- R2: Control bits [1:0] select the polynomial: 0 = 0x04C11DB7 over a 32-bit register, 1 = 0x1021, 2 = 0x3D65 and 3 = 0x8005, each over a 16-bit register. In the 16-bit modes, result bits [31:16] read as zero unless full-word output reversal is on.
- R3: A single write to address 0 loads all of the control bits [7:0] and also seeds the state. Bit 7 = 1 seeds all ones across the active width and bit 7 = 0 seeds zero. The seed is in place on the next clock. A read of address 0 returns the control bits in [7:0] with zeros above.
- R4: With control bit 2 = 0, each data write (address 1, or the DMA strobe) folds all 32 bits into the CRC in one clock, bit 31 first, after any input reordering. Writes may arrive on every clock.
- R5: With control bit 2 = 1, a data write folds only bits [7:0] of the formatted word, bit 7 first. Bits [31:8] of the write have no effect.
- R6: Control bit 3 reverses the bit order inside each byte of the data word before it is folded in.
- R7: Control bit 4 reverses the byte order of the data word before it is folded in. It has no effect in byte mode.
- R8: Control bit 5 enables output bit reversal. When bit 6 = 0 the whole 32-bit state is mirrored. When bit 6 = 1 the low 16 bits are mirrored and bits [31:16] read as zero. The reversal never alters the running state.
- R9: When a control write and a data write fall in the same clock, the data word is folded into the new seed using the new configuration.
- R10: When a bus data write and a DMA write fall in the same clock, the bus word is used and the DMA word is dropped.
- R11: A read request returns data one clock later. That data reflects every write completed before the clock of the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write enable |
| bus_re | input | 1 | Bus read enable |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 result |
| bus_wdata | input | 32 | Bus write data |
| dma_we | input | 1 | DMA write strobe into the data register |
| dma_wdata | input | 32 | DMA write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench goes after the standard check string in byte mode for every polynomial. A wrong tap set or a reflected shift shows up there as a mismatch against well-known check values. Random sessions mix every option combination with control writes that land in the same clock as data writes and with bus/DMA collisions. A design that folds data into the old state instead of the new seed, or that takes the DMA word, diverges at the next result read. Repeated result reads under output reversal expose a design that mirrors the stored state, and garbage in the upper bits during byte mode exposes one that leaks them into the CRC.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int CFG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd2;

  typedef enum logic [1:0] {
    POLY_W32_04C1 = 2'd0,
    POLY_H16_1021 = 2'd1,
    POLY_H16_3D65 = 2'd2,
    POLY_H16_8005 = 2'd3
  } poly_sel_e;

  typedef struct packed {
    logic      seed_ones;
    logic      out_half;
    logic      out_rev;
    logic      in_swap;
    logic      in_brev;
    logic      byte_mode;
    poly_sel_e poly;
  } crc_cfg_t;

  function automatic logic [WORD_W-1:0] poly_taps(input poly_sel_e sel);
    case (sel)
      POLY_W32_04C1: poly_taps = 32'h04C1_1DB7;
      POLY_H16_1021: poly_taps = 32'h0000_1021;
      POLY_H16_3D65: poly_taps = 32'h0000_3D65;
      default:       poly_taps = 32'h0000_8005;
    endcase
  endfunction

  function automatic logic poly_is_wide(input poly_sel_e sel);
    poly_is_wide = (sel == POLY_W32_04C1);
  endfunction

endpackage

// File: rtl/crc_input_fmt.sv
module crc_input_fmt
  import crc_accel_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int BW = BYTE_W
) (
  input  logic [DW-1:0] din,
  input  logic          brev,
  input  logic          swap,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / BW;

  logic [DW-1:0] rev_bits;
  logic [DW-1:0] swapped;

  genvar b, k;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      for (k = 0; k < BW; k++) begin : g_bit
        assign rev_bits[b*BW + k] = brev ? din[b*BW + (BW-1-k)] : din[b*BW + k];
      end
      assign swapped[b*BW +: BW] = rev_bits[(NB-1-b)*BW +: BW];
    end
  endgenerate

  assign dout = swap ? swapped : rev_bits;

endmodule

// File: rtl/crc_unrolled.sv
module crc_unrolled
  import crc_accel_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int HW = HALF_W,
  parameter int BW = BYTE_W
) (
  input  logic [DW-1:0] state_in,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] taps,
  input  logic          wide,
  input  logic          byte_mode,
  output logic [DW-1:0] state_out
);
  // stage[i] is the register after i bits have been folded
  logic [DW-1:0] stage [0:DW];
  logic [DW-1:0] src;

  // byte mode: put the low byte at the top so both paths share one chain
  assign src      = byte_mode ? {data_in[BW-1:0], {(DW-BW){1'b0}}} : data_in;
  assign stage[0] = state_in;

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_step
      logic          fb;
      logic [DW-1:0] sh;
      assign fb = (wide ? stage[i][DW-1] : stage[i][HW-1]) ^ src[DW-1-i];
      assign sh = wide ? {stage[i][DW-2:0], 1'b0}
                       : {{(DW-HW){1'b0}}, stage[i][HW-2:0], 1'b0};
      assign stage[i+1] = fb ? (sh ^ taps) : sh;
    end
  endgenerate

  assign state_out = byte_mode ? stage[BW] : stage[DW];

endmodule

// File: rtl/crc_readout.sv
module crc_readout
  import crc_accel_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int HW = HALF_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  crc_cfg_t      cfg,
  input  logic [DW-1:0] state,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rev_full;
  logic [DW-1:0] rev_half;
  logic [DW-1:0] result;

  genvar k;
  generate
    for (k = 0; k < DW; k++) begin : g_full
      assign rev_full[k] = state[DW-1-k];
    end
    for (k = 0; k < HW; k++) begin : g_half
      assign rev_half[k] = state[HW-1-k];
    end
  endgenerate
  assign rev_half[DW-1:HW] = '0;

  always_comb begin
    if (!cfg.out_rev)      result = state;
    else if (cfg.out_half) result = rev_half;
    else                   result = rev_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      case (addr)
        ADDR_CTRL:   rdata <= {{(DW-CFG_W){1'b0}}, cfg};
        ADDR_RESULT: rdata <= result;
        default:     rdata <= '0;
      endcase
    end
  end

  // R8
  half_rev_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (re && addr == ADDR_RESULT && cfg.out_rev && cfg.out_half) |=> (rdata[DW-1:HW] == '0));

  // R11
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (re && addr == ADDR_CTRL) |=> (rdata == {{(DW-CFG_W){1'b0}}, $past(cfg)}));

endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_accel_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int HW = HALF_W,
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          dma_we,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] bus_rdata
);
  crc_cfg_t      cfg_q;
  crc_cfg_t      cfg_eff;
  logic [DW-1:0] state_q;
  logic [DW-1:0] base;
  logic [DW-1:0] seed;
  logic [DW-1:0] word_raw;
  logic [DW-1:0] word_fmt;
  logic [DW-1:0] next_state;
  logic          ctrl_we;
  logic          bus_data_we;
  logic          data_we;
  logic          eff_wide;

  assign ctrl_we     = bus_we && (bus_addr == ADDR_CTRL);
  assign bus_data_we = bus_we && (bus_addr == ADDR_DATA);
  assign data_we     = bus_data_we || dma_we;

  // configuration in force for this clock's data (new one on a control write)
  assign cfg_eff  = ctrl_we ? crc_cfg_t'(bus_wdata[CFG_W-1:0]) : cfg_q;
  assign eff_wide = poly_is_wide(cfg_eff.poly);
  assign seed     = !cfg_eff.seed_ones ? '0 :
                    eff_wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
  assign base     = ctrl_we ? seed : state_q;
  assign word_raw = bus_data_we ? bus_wdata : dma_wdata;

  crc_input_fmt #(.DW(DW), .BW(BW)) u_fmt (
    .din  (word_raw),
    .brev (cfg_eff.in_brev),
    .swap (cfg_eff.in_swap && !cfg_eff.byte_mode),
    .dout (word_fmt)
  );

  crc_unrolled #(.DW(DW), .HW(HW), .BW(BW)) u_core (
    .state_in  (base),
    .data_in   (word_fmt),
    .taps      (poly_taps(cfg_eff.poly)),
    .wide      (eff_wide),
    .byte_mode (cfg_eff.byte_mode),
    .state_out (next_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      state_q <= '0;
    end else begin
      if (ctrl_we) cfg_q <= cfg_eff;
      if (data_we)      state_q <= next_state;
      else if (ctrl_we) state_q <= seed;
    end
  end

  crc_readout #(.DW(DW), .HW(HW), .AW(AW)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .re    (bus_re),
    .addr  (bus_addr),
    .cfg   (cfg_q),
    .state (state_q),
    .rdata (bus_rdata)
  );

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_CTRL) |=> (cfg_q == $past(bus_wdata[CFG_W-1:0])));

  // R4
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && !dma_we) |=> $stable(state_q));

  // R2
  half_state_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.poly != POLY_W32_04C1) |-> (state_q[DW-1:HW] == '0));

  // R3
  seed_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_CTRL && !dma_we && !bus_wdata[CFG_W-1]) |=> (state_q == '0));

endmodule

// File: tb/crc_accel_test.sv
module crc_accel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic        dma_we = 1'b0;
  logic [31:0] dma_wdata = '0;
  logic [31:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  m_cfg;
  logic [31:0] m_st;

  always #5 clk = ~clk;

  crc_accel uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dma_we(dma_we), .dma_wdata(dma_wdata), .bus_rdata(bus_rdata)
  );

  function automatic [31:0] ref_fmt(input [31:0] d, input [7:0] c);
    logic [31:0] r;
    r = d;
    if (c[3]) for (int b = 0; b < 4; b++) for (int k = 0; k < 8; k++) r[b*8+k] = d[b*8+7-k];
    if (c[4] && !c[2]) r = {r[7:0], r[15:8], r[23:16], r[31:24]};
    return r;
  endfunction

  function automatic [31:0] ref_fold(input [31:0] s0, input [31:0] d, input [7:0] c);
    logic [31:0] s, p;
    logic fb;
    int nb;
    s = s0;
    nb = c[2] ? 8 : 32;
    case (c[1:0])
      2'd0: p = 32'h04C11DB7;
      2'd1: p = 32'h1021;
      2'd2: p = 32'h3D65;
      default: p = 32'h8005;
    endcase
    for (int i = 0; i < nb; i++) begin
      if (c[1:0] == 2'd0) begin
        fb = s[31] ^ d[nb-1-i];
        s = s << 1;
      end else begin
        fb = s[15] ^ d[nb-1-i];
        s = {16'b0, s[14:0], 1'b0};
      end
      if (fb) s = s ^ p;
    end
    return s;
  endfunction

  function automatic [31:0] ref_seed(input [7:0] c);
    if (!c[7]) return 32'h0;
    return (c[1:0] == 2'd0) ? 32'hFFFFFFFF : 32'h0000FFFF;
  endfunction

  function automatic [31:0] ref_out(input [31:0] s, input [7:0] c);
    logic [31:0] r;
    if (!c[5]) return s;
    r = '0;
    if (c[6]) for (int k = 0; k < 16; k++) r[k] = s[15-k];
    else      for (int k = 0; k < 32; k++) r[k] = s[31-k];
    return r;
  endfunction

  task automatic check(input string tag, input [31:0] act, input [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model updates as the edge will
  task automatic step(input bit we, input [1:0] a, input [31:0] wd,
                      input bit dwe, input [31:0] dd, input bit re);
    logic [7:0] c;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    dma_we = dwe; dma_wdata = dd; bus_re = re;
    c = m_cfg;
    if (we && a == 2'd0) begin
      c = wd[7:0];
      m_st = ref_seed(c);
    end
    if (we && a == 2'd1)  m_st = ref_fold(m_st, ref_fmt(wd, c), c);
    else if (dwe)         m_st = ref_fold(m_st, ref_fmt(dd, c), c);
    m_cfg = c;
    @(negedge clk);
    bus_we = 0; dma_we = 0; bus_re = 0;
  endtask

  task automatic read_chk(input string tag, input [1:0] a);
    logic [31:0] exp;
    if (a == 2'd0)      exp = {24'b0, m_cfg};
    else if (a == 2'd2) exp = ref_out(m_st, m_cfg);
    else                exp = 32'h0;
    step(0, a, 0, 0, 0, 1);
    check(tag, bus_rdata, exp);
  endtask

  task automatic check_string(input [7:0] c, input [31:0] known, input string tag);
    string s;
    s = "123456789";
    step(1, 2'd0, {24'b0, c}, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(1, 2'd1, {24'hA5C3E1, s[i]}, 0, 0, 0);
    read_chk(tag, 2'd2);
    check({tag, " known value"}, bus_rdata, known);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    m_cfg = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    read_chk("R1 result after reset", 2'd2);
    read_chk("R1 control after reset", 2'd0);
    read_chk("R1 unmapped address", 2'd3);
    // R2 R5 check string per polynomial, byte mode, junk upper bits
    check_string(8'h84, 32'h0376E6E7, "R2 R5 poly 04C11DB7");
    check_string(8'h85, 32'h000029B1, "R2 R5 poly 1021");
    check_string(8'h06, 32'h00003D48, "R2 R5 poly 3D65");
    check_string(8'h07, 32'h0000FEE8, "R2 R5 poly 8005");
    // R3 seed and readback
    step(1, 2'd0, 32'hFFFF_FF80, 0, 0, 0);
    read_chk("R3 control readback", 2'd0);
    read_chk("R3 seed all ones", 2'd2);
    // R8 output reversal does not disturb state: read twice, then fold
    step(1, 2'd0, 32'h0000_00A0, 0, 0, 0);
    step(1, 2'd1, 32'h1234_5678, 0, 0, 0);
    read_chk("R8 full reversal", 2'd2);
    read_chk("R8 full reversal repeat", 2'd2);
    step(1, 2'd1, 32'h9ABC_DEF0, 0, 0, 0);
    read_chk("R8 state intact after read", 2'd2);
    step(1, 2'd0, 32'h0000_00E1, 0, 0, 0);
    step(1, 2'd1, 32'hCAFE_F00D, 0, 0, 0);
    read_chk("R8 half reversal", 2'd2);
    // R9 control and DMA data same clock
    step(1, 2'd0, 32'h0000_0098, 1, 32'h0BAD_BEEF, 0);
    read_chk("R9 seed then data", 2'd2);
    // R10 collision
    step(1, 2'd1, 32'h1111_2222, 1, 32'h3333_4444, 0);
    read_chk("R10 bus wins over dma", 2'd2);
    // R6 R7 back-to-back words
    step(1, 2'd0, 32'h0000_0098, 0, 0, 0);
    step(1, 2'd1, 32'h0102_0304, 0, 0, 0);
    step(0, 2'd0, 0, 1, 32'h8040_2010, 0);
    read_chk("R6 R7 swap and bit reversal", 2'd2);
    // random sessions
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0)      step(1, 2'd0, $urandom, $urandom_range(0, 1), $urandom, 0);
      else if (op < 4)  step(1, 2'd1, $urandom, $urandom_range(0, 1), $urandom, 0);
      else if (op < 6)  step(0, 2'd0, 0, 1, $urandom, 0);
      else if (op < 9)  read_chk("R4 R11 random result", 2'd2);
      else              read_chk("R3 random control", 2'd0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule